// File: doc/BRIEF.md
# 64-bit Comparing Event Counter

This block is a free-running 64-bit up-counter with one 64-bit compare register. Both are reached over a 32-bit register bus as pairs of 32-bit words. When the compare logic is enabled and the count is at or above the compare value, an event latches a sticky flag. The flag, gated by an interrupt enable, drives a single interrupt line.

An optional auto-advance mode adds a programmed step to the compare value on every event. This produces periodic interrupts while the counter itself never stops or reloads. Software reads the 64-bit count without tearing by reading the upper word, then the lower word, then the upper word again, and retrying if the two upper reads differ. The block keeps both words live so that this sequence works. Without auto-advance, one crossing gives exactly one event. A new event needs either a write to the compare value or the compare enable being turned off and back on.

Top module: `cmp_tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While control bit 0 (run) is set, the count rises by one every clock, and the carry passes from the lower word (offset 0x00) into the upper word (offset 0x04).
- R3: The count words accept bus writes only while run is clear. A write made while running is dropped and counting continues.
- R4: Control (0x08, bits 3:0), the compare words (0x10 lower, 0x14 upper) and the step (0x18) read back as written. Control bits above 3 read as zero.
- R5: When control bit 1 (compare enable) is set and the count is greater than or equal to the compare value in some cycle, status bit 0 (0x0C) reads one from the next clock. A count starting at 0 with compare value C therefore flags C+1 clocks after run is written.
- R6: Without auto-advance, a single crossing sets the flag only once. After it is cleared, the flag stays clear while the count remains at or above the compare value.
- R7: With control bit 3 (auto-advance) set, each event adds the step to the compare value. With compare C and step S, events occur at counts C, C+S, C+2S and so on.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R9: An event in the same cycle as a clear write leaves the flag set.
- R10: A bus write to a compare word in the same cycle as an auto-advance takes priority, and no step is added.
- R11: While compare enable is clear, no compare value and no count value sets the flag.
- R12: `irq` is the flag gated by control bit 2 (interrupt enable). A pending flag raises `irq` as soon as the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid in the same cycle as a read access |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle: an event with a flag clear write, and an auto-advance with a bus write to the compare value. Both are provoked with the counter stopped above the compare value, the step set to 1 and auto-advance on, so that an event happens every cycle. Every bus access in that window then collides with an event. The first pair is judged by reading the flag back as still set. The second is judged by reading back exactly the written compare value, with no step added, and by the flag staying clear afterwards.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
   // Word slot index = byte offset bits [4:2]
   localparam int unsigned SLOT_LSB = 2;
   localparam int unsigned SLOT_W   = 3;

   localparam logic [SLOT_W-1:0] SL_CNT_LO = 3'd0;
   localparam logic [SLOT_W-1:0] SL_CNT_HI = 3'd1;
   localparam logic [SLOT_W-1:0] SL_CTRL   = 3'd2;
   localparam logic [SLOT_W-1:0] SL_STAT   = 3'd3;
   localparam logic [SLOT_W-1:0] SL_CMP_LO = 3'd4;
   localparam logic [SLOT_W-1:0] SL_CMP_HI = 3'd5;
   localparam logic [SLOT_W-1:0] SL_STEP   = 3'd6;

   // Control word: bit0 run, bit1 compare enable, bit2 irq enable, bit3 auto-advance
   typedef struct packed {
      logic auto_en;
      logic irq_en;
      logic cmp_en;
      logic run;
   } ctrl_t;

   localparam int unsigned CTRL_W = 4;
endpackage

// File: rtl/ctm_counter.sv
module ctm_counter #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [DW-1:0]    wdata,
   output logic [CNT_W-1:0] cnt
);
   localparam int unsigned HALVES = CNT_W / DW;

   generate
      if (HALVES != 2 || (CNT_W % DW) != 0) begin : g_bad_split
         $error("ctm_counter: CNT_W must be exactly twice DW");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_d;
   logic [HALVES-1:0] wr_half;

   assign wr_half = {wr_hi, wr_lo};

   always_comb begin
      cnt_d = cnt_q;
      if (run) begin
         cnt_d = cnt_q + CNT_W'(1);
      end else begin
         for (int h = 0; h < int'(HALVES); h++) begin
            if (wr_half[h]) cnt_d[h*DW +: DW] = wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/ctm_compare.sv
module ctm_compare #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned DW     = 32,
   parameter int unsigned STEP_W = 32,
   parameter bit          CMP_GE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_en,
   input  logic              auto_en,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              wr_step,
   input  logic [DW-1:0]     wdata,
   input  logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  cmp,
   output logic [STEP_W-1:0] step,
   output logic              evt
);
   generate
      if (STEP_W < 1 || STEP_W > DW) begin : g_bad_step
         $error("ctm_compare: STEP_W must lie in 1..DW");
      end
      if (CNT_W != 2 * DW) begin : g_bad_cnt
         $error("ctm_compare: CNT_W must be exactly twice DW");
      end
   endgenerate

   logic [CNT_W-1:0]  cmp_q;
   logic [CNT_W-1:0]  cmp_d;
   logic [STEP_W-1:0] step_q;
   logic [CNT_W-1:0]  step_ext;
   logic              armed_q;
   logic              armed_d;
   logic              hit;
   logic              cmp_wr;

   // Match rule: magnitude (at or above) or exact equality
   generate
      if (CMP_GE) begin : g_ge
         assign hit = (cnt >= cmp_q);
      end else begin : g_eq
         assign hit = (cnt == cmp_q);
      end
   endgenerate

   generate
      if (STEP_W == CNT_W) begin : g_step_full
         assign step_ext = step_q;
      end else begin : g_step_pad
         assign step_ext = {{(CNT_W-STEP_W){1'b0}}, step_q};
      end
   endgenerate

   assign cmp_wr = wr_lo | wr_hi;
   assign evt    = cmp_en & armed_q & hit;

   // Bus writes take priority over the auto-advance
   always_comb begin
      cmp_d = cmp_q;
      if (cmp_wr) begin
         if (wr_lo) cmp_d[DW-1:0]     = wdata;
         if (wr_hi) cmp_d[CNT_W-1:DW] = wdata;
      end else if (evt && auto_en) begin
         cmp_d = cmp_q + step_ext;
      end
   end

   // One event per crossing unless re-armed by a new compare value or re-enable
   always_comb begin
      if (!cmp_en || cmp_wr)      armed_d = 1'b1;
      else if (evt && !auto_en)   armed_d = 1'b0;
      else                        armed_d = armed_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q   <= '0;
         step_q  <= '0;
         armed_q <= 1'b1;
      end else begin
         cmp_q   <= cmp_d;
         armed_q <= armed_d;
         if (wr_step) step_q <= wdata[STEP_W-1:0];
      end
   end

   assign cmp  = cmp_q;
   assign step = step_q;
endmodule

// File: rtl/ctm_regs.sv
module ctm_regs
   import ctm_pkg::*;
#(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned DW     = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned STEP_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  cmp,
   input  logic [STEP_W-1:0] step,
   input  logic              evt,
   output ctrl_t             ctrl,
   output logic              flag,
   output logic              clr_req,
   output logic              wr_cnt_lo,
   output logic              wr_cnt_hi,
   output logic              wr_cmp_lo,
   output logic              wr_cmp_hi,
   output logic              wr_step
);
   localparam int unsigned MAP_W = SLOT_LSB + SLOT_W;

   generate
      if (ADDR_W < MAP_W) begin : g_bad_addr
         $error("ctm_regs: ADDR_W too narrow for the register map");
      end
      if (DW < CTRL_W || STEP_W > DW) begin : g_bad_dw
         $error("ctm_regs: DW too narrow");
      end
   endgenerate

   logic [SLOT_W-1:0] slot;
   logic              in_map;
   logic              wr_go;
   logic              wr_ctrl;
   logic              wr_stat;
   ctrl_t             ctrl_q;
   logic              flag_q;
   logic              unused_addr_lsb;
   logic              unused_wdata_hi;

   assign slot            = bus_addr[SLOT_LSB +: SLOT_W];
   assign unused_addr_lsb = ^bus_addr[SLOT_LSB-1:0];
   assign unused_wdata_hi = ^bus_wdata[DW-1:CTRL_W];

   generate
      if (ADDR_W > MAP_W) begin : g_hi_addr
         assign in_map = (bus_addr[ADDR_W-1:MAP_W] == '0);
      end else begin : g_exact_addr
         assign in_map = 1'b1;
      end
   endgenerate

   assign wr_go     = bus_sel & bus_wr & in_map;
   assign wr_cnt_lo = wr_go & (slot == SL_CNT_LO);
   assign wr_cnt_hi = wr_go & (slot == SL_CNT_HI);
   assign wr_ctrl   = wr_go & (slot == SL_CTRL);
   assign wr_stat   = wr_go & (slot == SL_STAT);
   assign wr_cmp_lo = wr_go & (slot == SL_CMP_LO);
   assign wr_cmp_hi = wr_go & (slot == SL_CMP_HI);
   assign wr_step   = wr_go & (slot == SL_STEP);
   assign clr_req   = wr_stat & bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         // A new event outranks a clear in the same cycle
         if (evt)          flag_q <= 1'b1;
         else if (clr_req) flag_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr && in_map) begin
         case (slot)
            SL_CNT_LO: bus_rdata = cnt[DW-1:0];
            SL_CNT_HI: bus_rdata = cnt[CNT_W-1:DW];
            SL_CTRL:   bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            SL_STAT:   bus_rdata = {{(DW-1){1'b0}}, flag_q};
            SL_CMP_LO: bus_rdata = cmp[DW-1:0];
            SL_CMP_HI: bus_rdata = cmp[CNT_W-1:DW];
            SL_STEP:   bus_rdata = DW'(step);
            default:   bus_rdata = '0;
         endcase
      end
   end

   assign ctrl = ctrl_q;
   assign flag = flag_q;
endmodule

// File: rtl/cmp_tick_timer.sv
module cmp_tick_timer
   import ctm_pkg::*;
#(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned DW     = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned STEP_W = 32,
   parameter bit          CMP_GE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq
);
   ctrl_t             ctrl;
   logic              run;
   logic              cmp_en;
   logic              auto_en;
   logic              irq_en;
   logic              flag;
   logic              evt;
   logic              clr_req;
   logic              wr_cnt_lo;
   logic              wr_cnt_hi;
   logic              wr_cmp_lo;
   logic              wr_cmp_hi;
   logic              wr_step;
   logic              cnt_wr;
   logic              cmp_wr;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cmp;
   logic [STEP_W-1:0] step;

   assign run     = ctrl.run;
   assign cmp_en  = ctrl.cmp_en;
   assign auto_en = ctrl.auto_en;
   assign irq_en  = ctrl.irq_en;
   assign cnt_wr  = wr_cnt_lo | wr_cnt_hi;
   assign cmp_wr  = wr_cmp_lo | wr_cmp_hi;

   ctm_regs #(
      .CNT_W(CNT_W), .DW(DW), .ADDR_W(ADDR_W), .STEP_W(STEP_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cnt       (cnt),
      .cmp       (cmp),
      .step      (step),
      .evt       (evt),
      .ctrl      (ctrl),
      .flag      (flag),
      .clr_req   (clr_req),
      .wr_cnt_lo (wr_cnt_lo),
      .wr_cnt_hi (wr_cnt_hi),
      .wr_cmp_lo (wr_cmp_lo),
      .wr_cmp_hi (wr_cmp_hi),
      .wr_step   (wr_step)
   );

   ctm_counter #(
      .CNT_W(CNT_W), .DW(DW)
   ) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .wr_lo (wr_cnt_lo),
      .wr_hi (wr_cnt_hi),
      .wdata (bus_wdata),
      .cnt   (cnt)
   );

   ctm_compare #(
      .CNT_W(CNT_W), .DW(DW), .STEP_W(STEP_W), .CMP_GE(CMP_GE)
   ) u_compare (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp_en  (cmp_en),
      .auto_en (auto_en),
      .wr_lo   (wr_cmp_lo),
      .wr_hi   (wr_cmp_hi),
      .wr_step (wr_step),
      .wdata   (bus_wdata),
      .cnt     (cnt),
      .cmp     (cmp),
      .step    (step),
      .evt     (evt)
   );

   assign irq = flag & irq_en;
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned STEP_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              cmp_en,
   input logic              auto_en,
   input logic              flag,
   input logic              evt,
   input logic              irq,
   input logic              cnt_wr,
   input logic              cmp_wr,
   input logic              clr_req,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp,
   input logic [STEP_W-1:0] step
);
   a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> cnt == $past(cnt) + CNT_W'(1));

   a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt));

   a_r5_event_flags: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag);

   a_r6_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !auto_en && !cmp_wr) |=> !evt);

   a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && auto_en && !cmp_wr) |=> cmp == $past(cmp) + CNT_W'($past(step)));

   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !evt) |=> !flag);

   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && evt) |=> flag);

   a_r11_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_en && !flag) |=> !flag);

   a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !flag |-> !irq);
endmodule

bind cmp_tick_timer ctm_checker #(
   .CNT_W(CNT_W), .STEP_W(STEP_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run),
   .cmp_en  (cmp_en),
   .auto_en (auto_en),
   .flag    (flag),
   .evt     (evt),
   .irq     (irq),
   .cnt_wr  (cnt_wr),
   .cmp_wr  (cmp_wr),
   .clr_req (clr_req),
   .cnt     (cnt),
   .cmp     (cmp),
   .step    (step)
);

// File: tb/tb_cmp_tick_timer.sv
`timescale 1ns/1ps
module tb_cmp_tick_timer;
   localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08, A_ST = 5'h0C;
   localparam logic [4:0] A_MLO = 5'h10, A_MHI = 5'h14, A_STP = 5'h18;
   localparam logic [31:0] RUN = 32'h1, CEN = 32'h2, IEN = 32'h4, AUTO = 32'h8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          checks = 0;
   int          fails = 0;

   always #2.5 clk = ~clk;

   cmp_tick_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // All tasks start and end at a falling edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      while (!irq && n < 400) begin @(negedge clk); n++; end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d, d2;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      for (int a = 0; a < 7; a++) begin
         rd(5'(a*4), d);
         chk("R1 reset register", d, 0);
      end
      chk("R1 irq low", irq, 0);

      // R4: readback
      wr(A_STP, 32'h5A5A_1234); rd(A_STP, d); chk("R4 step", d, 32'h5A5A_1234);
      wr(A_MLO, 32'hDEAD_BEEF); rd(A_MLO, d); chk("R4 cmp lo", d, 32'hDEAD_BEEF);
      wr(A_MHI, 32'h1234_5678); rd(A_MHI, d); chk("R4 cmp hi", d, 32'h1234_5678);
      wr(A_CTL, 32'hFFFF_FFF4); rd(A_CTL, d); chk("R4 ctrl upper bits", d, 32'h4);
      wr(A_CTL, 0);

      // R11: compare at or below count, compare enable off
      wr(A_MLO, 0); wr(A_MHI, 0);
      repeat (5) @(negedge clk);
      rd(A_ST, d); chk("R11 no flag while disabled", d, 0);

      // R2/R3: load and carry
      wr(A_CLO, 32'hFFFF_FFFE); wr(A_CHI, 32'h3);
      rd(A_CLO, d); chk("R3 load lo stopped", d, 32'hFFFF_FFFE);
      rd(A_CHI, d); chk("R3 load hi stopped", d, 32'h3);
      wr(A_CTL, RUN); repeat (2) @(negedge clk); wr(A_CTL, 0);
      rd(A_CHI, d); rd(A_CLO, d2);
      chk("R2 carry", {d, d2}, 64'h4_0000_0001);
      wr(A_CTL, RUN); wr(A_CLO, 0); wr(A_CHI, 0); wr(A_CTL, 0);
      rd(A_CHI, d); rd(A_CLO, d2);
      chk("R3 writes while running dropped", {d, d2}, 64'h4_0000_0004);

      // R5: sweep of compare values, latency C+1 from run
      for (int c = 1; c <= 12; c++) begin
         wr(A_CTL, 0); wr(A_ST, 1);
         wr(A_CLO, 0); wr(A_CHI, 0); wr(A_MLO, 32'(c)); wr(A_MHI, 0);
         wr(A_CTL, RUN | CEN | IEN);
         wait_irq(n);
         chk("R5 event latency", 64'(n), 64'(c + 1));
      end

      // R6: cleared flag stays clear while count stays above compare
      wr(A_ST, 1);
      repeat (5) @(negedge clk);
      rd(A_ST, d); chk("R6 single crossing", d, 0);
      chk("R6 irq stays low", irq, 0);

      // R12: irq gating
      wr(A_CTL, 0); wr(A_ST, 1); wr(A_MLO, 0);
      wr(A_CTL, CEN);
      @(negedge clk);
      rd(A_ST, d); chk("R5 at-or-above match", d, 1);
      chk("R12 irq masked", irq, 0);
      wr(A_CTL, CEN | IEN);
      chk("R12 irq on enable", irq, 1);

      // R8: write-one-to-clear
      wr(A_ST, 0); rd(A_ST, d); chk("R8 write zero keeps flag", d, 1);
      wr(A_ST, 1); rd(A_ST, d); chk("R8 write one clears", d, 0);
      wr(A_CTL, 0);

      // R7: explicit period C=10 S=7
      wr(A_ST, 1); wr(A_CLO, 0); wr(A_CHI, 0);
      wr(A_MLO, 10); wr(A_MHI, 0); wr(A_STP, 7);
      wr(A_CTL, RUN | CEN | IEN | AUTO);
      wait_irq(n);
      chk("R7 first event", 64'(n), 11);
      wr(A_ST, 1); n++;
      chk("R7 cleared between events", irq, 0);
      while (!irq && n < 400) begin @(negedge clk); n++; end
      chk("R7 second event", 64'(n), 18);
      rd(A_MLO, d); chk("R7 compare advanced twice", d, 24);

      // R7: sweep of compare and step, checked by the final compare value
      for (int c = 3; c <= 6; c += 3) begin
         for (int s = 1; s <= 5; s++) begin
            int k, f;
            k = 10 + 3 * s;
            f = k + 1;
            wr(A_CTL, 0); wr(A_ST, 1); wr(A_CLO, 0); wr(A_CHI, 0);
            wr(A_MLO, 32'(c)); wr(A_MHI, 0); wr(A_STP, 32'(s));
            wr(A_CTL, RUN | CEN | AUTO);
            repeat (k) @(negedge clk);
            wr(A_CTL, CEN | AUTO);
            repeat (40) @(negedge clk);
            rd(A_CLO, d); chk("R2 run length", d, 32'(f));
            rd(A_MLO, d);
            chk("R7 final compare", d, 32'(c + s * ((f - c) / s + 1)));
         end
      end

      // R9/R10: events every cycle with the counter stopped above the compare value
      wr(A_CTL, 0); wr(A_ST, 1);
      wr(A_CLO, 100); wr(A_CHI, 0); wr(A_MLO, 0); wr(A_MHI, 0); wr(A_STP, 1);
      wr(A_CTL, CEN | AUTO);
      wr(A_ST, 1); rd(A_ST, d); chk("R9 set beats clear", d, 1);
      wr(A_ST, 1); rd(A_ST, d); chk("R9 set beats clear again", d, 1);
      wr(A_MLO, 32'h1000);
      rd(A_MLO, d); chk("R10 bus write beats advance", d, 32'h1000);
      wr(A_ST, 1);
      repeat (3) @(negedge clk);
      rd(A_ST, d); chk("R10 no event after rewrite", d, 0);
      wr(A_CTL, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule